// File: doc/BRIEF.md
# Double-Buffered Serial Divider Programming Loader

This block receives the divider control word of a frequency synthesizer over a three-wire serial link and presents it to the counters. Serial data shifts into a 20-bit primary register. A rising edge on the write strobe copies the primary register into a 20-bit secondary register. A frequency-select input chooses which of the two drives the counter word. With this arrangement, two channel settings can be held at once, and the counters can switch between them with a single pin.

A second, 8-bit path loads enhancement control bits. It is used when the enhancement select is high. Its shift register is buffered: the buffer captures the shifted value only when the select falls, so the control outputs never show partial data. The buffered bits reach the outputs only while the active-low enhancement enable is asserted.

All serial-side inputs are sampled on the block clock `clk_i`. Edges of the serial clock and of the strobes are found by comparing each sample with the one from the previous cycle. A register updates on the first `clk_i` edge at which the new input level is seen.

Top module: `synth_prog_loader`

## Requirements
- R1: While `rst_ni` is low, all registers are cleared, so `word_o` and `enh_o` read zero.
- R2: When `ensel_i`=0 and `wr_i`=0, each rising edge of `sclk_i` shifts the primary register left by one, with `sdata_i` entering bit 0. After 20 edges, the first bit sent sits in bit 19 (MSB first).
- R3: When more than 20 bits are shifted, the primary register holds only the last 20 bits sent.
- R4: A rising edge of `wr_i` copies the primary register into the secondary register. At all other times the secondary register holds its value.
- R5: When `fsel_i`=1, `word_o` shows the primary register. When `fsel_i`=0, it shows the secondary register.
- R6: When `ensel_i`=1 and `wr_i`=0, rising edges of `sclk_i` shift the 8-bit enhancement shift register the same way, MSB first, into bit 0. The primary register does not change.
- R7: A falling edge of `ensel_i` captures the enhancement shift register into the enhancement buffer. `enh_o` does not change while bits are being shifted.
- R8: When `enh_n_i`=0, `enh_o` shows the enhancement buffer. When `enh_n_i`=1, `enh_o` is all zeros.
- R9: Rising edges of `sclk_i` while `wr_i`=1 shift neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock; samples all serial-side inputs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data shifts in on its rising edge |
| sdata_i | input | 1 | Serial data, MSB first |
| wr_i | input | 1 | Write strobe; its rising edge loads the secondary register; blocks shifting while high |
| ensel_i | input | 1 | Selects the enhancement path; its falling edge captures the enhancement bits |
| fsel_i | input | 1 | Selects the counter word source: 1 primary, 0 secondary |
| enh_n_i | input | 1 | Active-low enable for the enhancement outputs |
| word_o | output | 20 | Active counter control word |
| enh_o | output | 8 | Enhancement control bits |

## Verification
The bench sends a word of 25 bits to show that only the last 20 survive. A design that keeps the oldest bits, or that shifts the wrong way, returns a rotated or truncated word. It loads a second word while `fsel_i` is low. A secondary register that follows the primary instead of waiting for the strobe shows the new word too early. It checks `enh_o` in the middle of an enhancement load and again after the select falls. A path that is not buffered leaks partial bits, and a path that captures on the wrong edge never updates. Finally, it pulses `sclk_i` with the strobe high and with the enhancement select high. A design that does not qualify the shift with these inputs corrupts the primary word.

// File: rtl/spl_pkg.sv
package spl_pkg;
  localparam int unsigned MAIN_W = 20;
  localparam int unsigned ENH_W  = 8;
endpackage

// File: rtl/spl_edge_det.sv
module spl_edge_det #(
  parameter bit RISE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic edge_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  generate
    if (RISE) begin : g_rise
      assign edge_o = lvl_i & ~lvl_q;
    end else begin : g_fall
      assign edge_o = ~lvl_i & lvl_q;
    end
  endgenerate
endmodule

// File: rtl/spl_shift_reg.sv
module spl_shift_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= {q_o[W-2:0], d_i};
  end
endmodule

// File: rtl/spl_hold_reg.sv
module spl_hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/synth_prog_loader.sv
module synth_prog_loader #(
  parameter int unsigned MAIN_W = spl_pkg::MAIN_W,
  parameter int unsigned ENH_W  = spl_pkg::ENH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              wr_i,
  input  logic              ensel_i,
  input  logic              fsel_i,
  input  logic              enh_n_i,
  output logic [MAIN_W-1:0] word_o,
  output logic [ENH_W-1:0]  enh_o
);
  logic sclk_rise, wr_rise, ensel_fall;
  logic prim_shift, enh_shift;
  logic [MAIN_W-1:0] prim_q, sec_q;
  logic [ENH_W-1:0]  enh_sr_q, enh_buf_q;

  spl_edge_det #(.RISE(1'b1)) u_sclk_edge (
    .clk_i, .rst_ni, .lvl_i(sclk_i), .edge_o(sclk_rise));
  spl_edge_det #(.RISE(1'b1)) u_wr_edge (
    .clk_i, .rst_ni, .lvl_i(wr_i), .edge_o(wr_rise));
  spl_edge_det #(.RISE(1'b0)) u_ensel_edge (
    .clk_i, .rst_ni, .lvl_i(ensel_i), .edge_o(ensel_fall));

  // shifting blocked while the write strobe is high
  assign prim_shift = sclk_rise & ~wr_i & ~ensel_i;
  assign enh_shift  = sclk_rise & ~wr_i &  ensel_i;

  spl_shift_reg #(.W(MAIN_W)) u_prim (
    .clk_i, .rst_ni, .en_i(prim_shift), .d_i(sdata_i), .q_o(prim_q));
  spl_hold_reg #(.W(MAIN_W)) u_sec (
    .clk_i, .rst_ni, .ld_i(wr_rise), .d_i(prim_q), .q_o(sec_q));
  spl_shift_reg #(.W(ENH_W)) u_enh_sr (
    .clk_i, .rst_ni, .en_i(enh_shift), .d_i(sdata_i), .q_o(enh_sr_q));
  spl_hold_reg #(.W(ENH_W)) u_enh_buf (
    .clk_i, .rst_ni, .ld_i(ensel_fall), .d_i(enh_sr_q), .q_o(enh_buf_q));

  assign word_o = fsel_i  ? prim_q : sec_q;
  assign enh_o  = enh_n_i ? '0     : enh_buf_q;

  p_shift_in_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise && !wr_i && !ensel_i) |=> (prim_q[0] == $past(sdata_i)));
  p_wr_blocks_shift_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> $stable(prim_q));
  p_enh_keeps_prim_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ensel_i |=> $stable(prim_q));
  p_sec_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rise |=> (sec_q == $past(prim_q)));
  p_sec_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_rise |=> $stable(sec_q));
  p_enh_buf_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ensel_i |=> $stable(enh_buf_q));
  p_enh_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enh_n_i |-> (enh_o == '0));
endmodule

// File: tb/synth_prog_loader_bench.sv
`timescale 1ns/1ps
module synth_prog_loader_bench;
  localparam int MW = 20;
  localparam int EW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 0, sdata = 0, wr = 0, ensel = 0, fsel = 1, enh_n = 0;
  logic [MW-1:0] word;
  logic [EW-1:0] enh;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  synth_prog_loader u_synth_prog_loader (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .wr_i(wr),
    .ensel_i(ensel), .fsel_i(fsel), .enh_n_i(enh_n), .word_o(word), .enh_o(enh));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sdata = b; wait_n(1);
    sclk = 1;  wait_n(2);
    sclk = 0;  wait_n(2);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic strobe();
    wr = 1; wait_n(2);
    wr = 0; wait_n(2);
  endtask

  task automatic t_reset();
    fsel = 1; check("R1 word after reset", 32'(word), 0);
    enh_n = 0; check("R1 enh after reset", 32'(enh), 0);
  endtask

  task automatic t_primary_and_select();
    send(32'hA5C3E, MW);
    fsel = 1; wait_n(1); check("R2 primary MSB first", 32'(word), 32'hA5C3E);
    fsel = 0; wait_n(1); check("R5 secondary before strobe", 32'(word), 0);
    strobe();
    check("R4 secondary loaded", 32'(word), 32'hA5C3E);
    send(32'h1F0F1, MW);
    check("R4 secondary holds", 32'(word), 32'hA5C3E);
    fsel = 1; wait_n(1); check("R5 primary selected", 32'(word), 32'h1F0F1);
  endtask

  task automatic t_overshift();
    send(32'h15, 5);
    send(32'h6B2D9, MW);
    check("R3 last 20 bits kept", 32'(word), 32'h6B2D9);
  endtask

  task automatic t_wr_blocks();
    wr = 1; wait_n(1);
    bit_out(1); bit_out(0); bit_out(1);
    wr = 0; wait_n(2);
    check("R9 no shift while wr high", 32'(word), 32'h6B2D9);
  endtask

  task automatic t_enh();
    enh_n = 0;
    ensel = 1; wait_n(2);
    send(32'hC6, EW);
    check("R7 enh unchanged while shifting", 32'(enh), 0);
    check("R6 primary untouched", 32'(word), 32'h6B2D9);
    ensel = 0; wait_n(2);
    check("R7 enh captured on fall", 32'(enh), 32'hC6);
    enh_n = 1; wait_n(1); check("R8 disabled forces zero", 32'(enh), 0);
    enh_n = 0; wait_n(1); check("R8 enabled shows buffer", 32'(enh), 32'hC6);
  endtask

  initial begin
    wait_n(3);
    t_reset();
    rst_n = 1; wait_n(2);
    t_primary_and_select();
    t_overshift();
    t_wr_blocks();
    t_enh();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule